// File: doc/BRIEF.md
# Button Conditioner and Edge Detector

This block sits after a game-pad reader. Once per frame it receives an 8-bit button byte with the action buttons in the upper nibble and the four directions in the lower nibble. It removes direction combinations that a worn pad can produce but a game should never see. When such a combination arrives, the block keeps the direction nibble from the previous conditioned frame and still passes the current action nibble through.

A mode input picks the filter for each frame:

- **Two-axis mode** rejects opposing directions, that is Up with Down, or Left with Right.
- **Four-way mode** rejects any combination of more than one direction, which emulates a four-way stick.

From the same frame update, the block also produces a newly-pressed mask and a newly-released mask. Both are computed against the stored conditioned byte of the previous frame.

Every output is a register. Outputs load only on a cycle where the frame strobe is high and change on the next clock edge.

Top module: `btn_shaper`

## Requirements
- R1: While reset is asserted and after its release, before any frame strobe, `cleanButtons`, `pressedMask` and `releasedMask` are all 0x00.
- R2: On clock edges where `frameValid` is low, all three outputs keep their values whatever `rawButtons` and `modeFourWay` do.
- R3: With `modeFourWay` = 0, a frame is in conflict when bit 3 (Up) and bit 2 (Down) are both set, or when bit 1 (Left) and bit 0 (Right) are both set.
- R4: With `modeFourWay` = 1, a frame is in conflict when more than one of bits 3..0 is set.
- R5: On a strobed frame, `cleanButtons` becomes `rawButtons` when there is no conflict. On a conflict it becomes `rawButtons[7:4]` concatenated with the previous `cleanButtons[3:0]`. The update is visible one clock after the strobe edge.
- R6: On a strobed frame, `pressedMask` becomes new-clean AND NOT old-clean, bit by bit.
- R7: On a strobed frame, `releasedMask` becomes old-clean AND NOT new-clean, bit by bit.
- R8: `pressedMask` and `releasedMask` never have a bit set in the same position.
- R9: The stored previous byte is 0x00 after reset, so any button held in the first strobed frame appears in `pressedMask`.
- R10: Two-axis mode accepts a diagonal such as Up+Right unchanged. Four-way mode accepts a single direction, or no direction, unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| frameValid | input | 1 | Frame strobe; inputs are taken on edges where this is high |
| modeFourWay | input | 1 | 0 = reject opposing directions, 1 = reject any diagonal |
| rawButtons | input | 8 | Raw button byte: bits 7..4 are action buttons, 3 = Up, 2 = Down, 1 = Left, 0 = Right |
| cleanButtons | output | 8 | Conditioned button byte of the latest frame |
| pressedMask | output | 8 | Buttons newly pressed in the latest frame |
| releasedMask | output | 8 | Buttons newly released in the latest frame |

## Verification
The bench targets the following corner cases:

- **Conflict followed by a press.** A conflict frame keeps the old direction nibble while an action button changes in the same frame. A design that fell back on the whole byte would lose the action press. A design that used the raw nibble would leak Up+Down through.
- **Mode switching.** Diagonals are sent in both modes. A filter wired to the wrong mode would either drop legal diagonals in two-axis mode or pass them in four-way mode.
- **Reference for the edge masks.** Strobe-free stretches carry changing raw input, and the first frame after reset holds buttons down. Masks computed against the raw history instead of the conditioned history would report phantom presses after a rejected frame. A register that loaded without the strobe would drift between frames.

// File: rtl/btn_shaper_pkg.sv
package btn_shaper_pkg;

  // Strobes from the control decision to the datapath registers.
  typedef struct packed {
    logic loadFrame;  // take a new frame on this edge
    logic useOldDir;  // direction nibble falls back to the stored one
  } shapeCtrl_t;

endpackage

// File: rtl/btn_shaper_ctrl.sv
module btn_shaper_ctrl
  import btn_shaper_pkg::*;
#(
  parameter int DIR_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameValid,
  input  logic             modeFourWay,
  input  logic [DIR_W-1:0] rawDir,
  output shapeCtrl_t       ctl
);

  localparam int PAIRS = DIR_W / 2;
  localparam logic [DIR_W-1:0] LOW_OF_PAIR = {PAIRS{2'b01}};

  logic [PAIRS-1:0] pairHit;
  logic             opposeHit;
  logic             manyHit;

  // One opposing pair per two direction bits: (Up,Down) and (Left,Right).
  for (genvar g = 0; g < PAIRS; g++) begin : g_pair
    assign pairHit[g] = rawDir[2*g+1] & rawDir[2*g];
  end

  assign opposeHit = |pairHit;
  // More than one bit set: n & (n-1) is non-zero.
  assign manyHit   = |(rawDir & (rawDir - DIR_W'(1)));

  always_comb begin
    ctl.loadFrame = frameValid;
    ctl.useOldDir = modeFourWay ? manyHit : opposeHit;
  end

  // R3: opposing pair in two-axis mode must raise the fallback.
  p_oppose_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!modeFourWay && ((rawDir & (rawDir >> 1) & LOW_OF_PAIR) != '0)) |-> ctl.useOldDir);

  // R4: four-way mode falls back exactly when several directions are set.
  p_fourway_r4: assert property (@(posedge clk) disable iff (!rstN)
    modeFourWay |-> (ctl.useOldDir == ($countones(rawDir) > 1)));

  // R10: a lone direction is never rejected in either mode.
  p_single_ok_r10: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(rawDir) <= 1) |-> !ctl.useOldDir);

endmodule

// File: rtl/btn_shaper_dp.sv
module btn_shaper_dp
  import btn_shaper_pkg::*;
#(
  parameter int BTN_W = 8,
  parameter int DIR_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  shapeCtrl_t       ctl,
  input  logic [BTN_W-1:0] rawButtons,
  output logic [BTN_W-1:0] cleanButtons,
  output logic [BTN_W-1:0] pressedMask,
  output logic [BTN_W-1:0] releasedMask
);

  logic [BTN_W-1:0] cleanReg;
  logic [BTN_W-1:0] pressReg;
  logic [BTN_W-1:0] relReg;
  logic [BTN_W-1:0] nextClean;

  always_comb begin
    nextClean = rawButtons;
    if (ctl.useOldDir)
      nextClean[DIR_W-1:0] = cleanReg[DIR_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cleanReg <= '0;
      pressReg <= '0;
      relReg   <= '0;
    end else if (ctl.loadFrame) begin
      cleanReg <= nextClean;
      pressReg <= nextClean & ~cleanReg;
      relReg   <= cleanReg & ~nextClean;
    end
  end

  assign cleanButtons = cleanReg;
  assign pressedMask  = pressReg;
  assign releasedMask = relReg;

  // R2: nothing moves without a frame strobe.
  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.loadFrame |=> ($stable(cleanButtons) && $stable(pressedMask) && $stable(releasedMask)));

  // R5: on fallback, action nibble is live and direction nibble is the old one.
  p_fallback_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.loadFrame && ctl.useOldDir) |=>
      (cleanButtons[DIR_W-1:0] == $past(cleanButtons[DIR_W-1:0]) &&
       cleanButtons[BTN_W-1:DIR_W] == $past(rawButtons[BTN_W-1:DIR_W])));

  // R6: pressed mask relates old and new conditioned bytes.
  p_press_r6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadFrame |=> (pressedMask == (cleanButtons & ~$past(cleanButtons))));

  // R7: released mask relates old and new conditioned bytes.
  p_release_r7: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadFrame |=> (releasedMask == ($past(cleanButtons) & ~cleanButtons)));

  // R8: press and release never overlap.
  p_disjoint_r8: assert property (@(posedge clk) disable iff (!rstN)
    (pressedMask & releasedMask) == '0);

endmodule

// File: rtl/btn_shaper.sv
module btn_shaper
  import btn_shaper_pkg::*;
#(
  parameter int BTN_W = 8,
  parameter int DIR_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameValid,
  input  logic             modeFourWay,
  input  logic [BTN_W-1:0] rawButtons,
  output logic [BTN_W-1:0] cleanButtons,
  output logic [BTN_W-1:0] pressedMask,
  output logic [BTN_W-1:0] releasedMask
);

  shapeCtrl_t ctl;

  btn_shaper_ctrl #(.DIR_W(DIR_W)) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .frameValid (frameValid),
    .modeFourWay(modeFourWay),
    .rawDir     (rawButtons[DIR_W-1:0]),
    .ctl        (ctl)
  );

  btn_shaper_dp #(.BTN_W(BTN_W), .DIR_W(DIR_W)) i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .rawButtons  (rawButtons),
    .cleanButtons(cleanButtons),
    .pressedMask (pressedMask),
    .releasedMask(releasedMask)
  );

  // R1: reset clears every output.
  p_reset_r1: assert property (@(posedge clk)
    !rstN |=> (!rstN || (cleanButtons == '0 && pressedMask == '0 && releasedMask == '0)) );

endmodule

// File: tb/test_btn_shaper.sv
`timescale 1ns/1ps
module test_btn_shaper;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       frameValid = 1'b0;
  logic       modeFourWay = 1'b0;
  logic [7:0] rawButtons = 8'h00;
  logic [7:0] cleanButtons, pressedMask, releasedMask;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // Reference model state.
  int mClean = 0, mPress = 0, mRel = 0;

  always #10 clk = ~clk;

  btn_shaper i_btn_shaper (
    .clk(clk), .rstN(rstN), .frameValid(frameValid), .modeFourWay(modeFourWay),
    .rawButtons(rawButtons), .cleanButtons(cleanButtons),
    .pressedMask(pressedMask), .releasedMask(releasedMask)
  );

  // Behavioural reference, updated on each rising edge.
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mClean = 0; mPress = 0; mRel = 0;
    end else if (frameValid) begin
      int d, cnt, nc;
      bit bad;
      d = rawButtons & 15;
      cnt = 0;
      for (int i = 0; i < 4; i++) if ((d >> i) & 1) cnt++;
      if (modeFourWay) bad = (cnt > 1);
      else bad = ((d & 12) == 12) || ((d & 3) == 3);
      nc = bad ? ((rawButtons & 240) | (mClean & 15)) : int'(rawButtons);
      mPress = nc & ~mClean & 255;
      mRel   = mClean & ~nc & 255;
      mClean = nc;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-clock comparison against the model, away from the active edge.
  always @(negedge clk) begin
    if (rstN && !done) begin
      chk("R5 clean vs model", cleanButtons, mClean);
      chk("R6 pressed vs model", pressedMask, mPress);
      chk("R7 released vs model", releasedMask, mRel);
      chk("R8 overlap", pressedMask & releasedMask, 0);
    end
  end

  task automatic frame(bit m, logic [7:0] raw);
    @(negedge clk);
    frameValid = 1'b1; modeFourWay = m; rawButtons = raw;
    @(negedge clk);
    frameValid = 1'b0;
  endtask

  task automatic expectOut(string tag, int c, int p, int r);
    chk({tag, " clean"}, cleanButtons, c);
    chk({tag, " pressed"}, pressedMask, p);
    chk({tag, " released"}, releasedMask, r);
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finishRun();
    end
  end

  initial begin
    rawButtons = 8'hFF;
    repeat (3) @(negedge clk);
    expectOut("R1 in reset", 0, 0, 0);
    rstN = 1'b1;
    @(negedge clk);
    expectOut("R1 after reset", 0, 0, 0);

    frame(1'b0, 8'h81);                 // A + Right, first frame
    expectOut("R9 first frame", 8'h81, 8'h81, 0);

    frame(1'b0, 8'h0C);                 // Up + Down, A released
    expectOut("R3 up-down reject", 8'h01, 0, 8'h80);

    frame(1'b0, 8'h09);                 // Up + Right diagonal legal
    expectOut("R10 diagonal two-axis", 8'h09, 8'h08, 0);

    frame(1'b0, 8'h43);                 // B + Left + Right
    expectOut("R3 left-right reject", 8'h49, 8'h40, 0);

    frame(1'b1, 8'h05);                 // Down + Right in four-way
    expectOut("R4 diagonal reject", 8'h09, 0, 8'h40);

    frame(1'b1, 8'h24);                 // Select + Down
    expectOut("R10 single four-way", 8'h24, 8'h24, 8'h09);

    frame(1'b1, 8'h10);                 // Start, no direction
    expectOut("R10 none four-way", 8'h10, 8'h10, 8'h24);

    @(negedge clk);
    rawButtons = 8'hFF; modeFourWay = 1'b0;
    repeat (3) @(negedge clk);
    expectOut("R2 hold without strobe", 8'h10, 8'h10, 8'h24);

    // Random stretch against the model.
    for (int n = 0; n < 2000; n++) begin
      @(negedge clk);
      frameValid  = ($urandom_range(0, 2) != 0);
      modeFourWay = $urandom_range(0, 1);
      rawButtons  = 8'($urandom_range(0, 255));
    end
    @(negedge clk);
    frameValid = 1'b0;
    @(negedge clk);
    finishRun();
  end

endmodule